// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit lets a small microcontroller use its 14-bit program memory as lookup tables. Software loads an 8-bit table pointer through the register file and then issues a table read. The read either stays in the 256-word page that holds the current program counter or goes to the top page of a 1024-word program memory. The unit forms the program-memory address, fetches the word and hands back its low byte on a one-cycle done strobe, for the core to write into data memory. It keeps the six remaining upper bits in a read-only high register.

The pointer is readable and writable at register address 07H. The high register is readable at 08H, with its two top bits always zero. A read takes two cycles. In the first cycle the address and a read strobe go to program memory. In the second cycle the word is captured, the high register is updated and done is raised. The program memory itself is outside this block and answers combinationally during the strobe cycle.

Top module: `tbl_read_unit`

## Requirements
- R1: After reset the table pointer and the high register both read 0, and `done` and `pm_rd` are low.
- R2: A request with `req_last_page`=0 fetches address {`pc_page`, pointer}, where `pc_page` is sampled in the cycle the request is accepted.
- R3: A request with `req_last_page`=1 fetches address 300H + pointer, so the top two address bits are both 1.
- R4: In the cycle `done` is high, `lo_byte` equals bits 7..0 of the fetched word.
- R5: From the done cycle on, reading address 08H returns {2'b00, bits 13..8 of the fetched word}.
- R6: Address 07H reads back the last value written to it. Reading any address other than 07H or 08H returns 0.
- R7: A write to address 08H leaves the high register unchanged.
- R8: A request that is accepted while idle raises `pm_rd` with the address in the next cycle. `done` follows in the cycle after that and lasts one cycle.
- R9: A request in the `pm_rd` cycle is ignored. A request in the `done` cycle is accepted.
- R10: If a pointer write and a request arrive in the same cycle, the fetch uses the pointer value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register-file write strobe |
| reg_addr | input | 8 | Register-file address |
| reg_wdata | input | 8 | Register-file write data |
| reg_rdata | output | 8 | Register-file read data (combinational) |
| req | input | 1 | Table read request |
| req_last_page | input | 1 | 1 = top page, 0 = current page |
| pc_page | input | 2 | Program counter bits 9..8 |
| pm_addr | output | 10 | Program-memory address |
| pm_rd | output | 1 | Program-memory read strobe |
| pm_data | input | 14 | Program-memory word |
| done | output | 1 | Read completes this cycle |
| lo_byte | output | 8 | Low byte of the fetched word |

## Verification
The assertions assume that program memory returns a settled `pm_data` during every `pm_rd` cycle. They also assume that `pc_page` and `req_last_page` are valid whenever `req` is high. The bench meets both assumptions with a combinational memory model driven from `pm_addr`, and by changing every input only at the falling clock edge. Requests that arrive during a fetch are expected to have no effect. The bench therefore drives them on purpose with different page settings, so that a wrongly accepted request would show up as a different address.

// File: rtl/tbl_read_pkg.sv
package tbl_read_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [0:0] {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/tbl_fetch_ctrl.sv
module tbl_fetch_ctrl
  import tbl_read_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int PTR_W = 8,
  localparam int PG_W = PC_W - PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_last,
  input  logic [PG_W-1:0]  page,
  input  logic [PTR_W-1:0] ptr,
  output logic [PC_W-1:0]  pm_addr,
  output logic             pm_rd,
  output logic             accept,
  output logic             capture
);
  fetch_state_e state_q;

  // Address arithmetic: page bits from PC, or all ones for the top page.
  function automatic logic [PC_W-1:0] form_addr(input logic last,
                                                input logic [PG_W-1:0] pg,
                                                input logic [PTR_W-1:0] p);
    logic [PG_W-1:0] hi;
    hi = last ? {PG_W{1'b1}} : pg;
    return {hi, p};
  endfunction

  assign accept  = req && (state_q == FS_IDLE);
  assign capture = (state_q == FS_FETCH);
  assign pm_rd   = capture;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      pm_addr <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE:  if (accept) state_q <= FS_FETCH;
        FS_FETCH: state_q <= FS_IDLE;
        default:  state_q <= FS_IDLE;
      endcase
      if (accept) pm_addr <= form_addr(req_last, page, ptr);
    end
  end
endmodule

// File: rtl/tbl_regs.sv
module tbl_regs
  import tbl_read_pkg::*;
#(
  parameter int               HI_W     = 6,
  parameter int               RA_W     = 8,
  parameter logic [RA_W-1:0]  PTR_ADDR = 8'h07,
  parameter logic [RA_W-1:0]  HI_ADDR  = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RA_W-1:0]   addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [HI_W-1:0]   fetched_hi,
  output logic [DATA_W-1:0] ptr_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_W = DATA_W - HI_W;

  function automatic logic [DATA_W-1:0] pad_hi(input logic [HI_W-1:0] h);
    return {{PAD_W{1'b0}}, h};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      if (wr_en && addr == PTR_ADDR) ptr_q <= wdata;
      if (capture) hi_q <= fetched_hi;
    end
  end

  always_comb begin
    if (addr == PTR_ADDR)     rdata = ptr_q;
    else if (addr == HI_ADDR) rdata = pad_hi(hi_q);
    else                      rdata = '0;
  end
endmodule

// File: rtl/tbl_out_stage.sv
module tbl_out_stage
  import tbl_read_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] word_lo,
  output logic              done,
  output logic [DATA_W-1:0] lo_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      lo_byte <= '0;
    end else begin
      done <= capture;
      if (capture) lo_byte <= word_lo;
    end
  end
endmodule

// File: rtl/tbl_read_unit.sv
module tbl_read_unit
  import tbl_read_pkg::*;
#(
  parameter int              WORD_W   = 14,
  parameter int              PC_W     = 10,
  parameter int              RA_W     = 8,
  parameter logic [RA_W-1:0] PTR_ADDR = 8'h07,
  parameter logic [RA_W-1:0] HI_ADDR  = 8'h08,
  localparam int             PG_W     = PC_W - DATA_W,
  localparam int             HI_W     = WORD_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req,
  input  logic              req_last_page,
  input  logic [PG_W-1:0]   pc_page,
  output logic [PC_W-1:0]   pm_addr,
  output logic              pm_rd,
  input  logic [WORD_W-1:0] pm_data,
  output logic              done,
  output logic [DATA_W-1:0] lo_byte
);
  // Named internal events for the checker.
  logic              accept;
  logic              capture;
  logic [DATA_W-1:0] ptr_q;
  logic [HI_W-1:0]   hi_q;

  tbl_fetch_ctrl #(.PC_W(PC_W), .PTR_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_last(req_last_page),
    .page(pc_page), .ptr(ptr_q), .pm_addr(pm_addr), .pm_rd(pm_rd),
    .accept(accept), .capture(capture)
  );

  tbl_regs #(.HI_W(HI_W), .RA_W(RA_W), .PTR_ADDR(PTR_ADDR), .HI_ADDR(HI_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .capture(capture), .fetched_hi(pm_data[WORD_W-1:DATA_W]),
    .ptr_q(ptr_q), .hi_q(hi_q), .rdata(reg_rdata)
  );

  tbl_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .word_lo(pm_data[DATA_W-1:0]), .done(done), .lo_byte(lo_byte)
  );
endmodule

// File: rtl/tbl_read_chk.sv
module tbl_read_chk #(
  parameter int              WORD_W  = 14,
  parameter int              PC_W    = 10,
  parameter int              PG_W    = 2,
  parameter int              HI_W    = 6,
  parameter int              RA_W    = 8,
  parameter logic [RA_W-1:0] HI_ADDR = 8'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_last_page,
  input logic [PG_W-1:0]   pc_page,
  input logic [RA_W-1:0]   reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              pm_rd,
  input logic [PC_W-1:0]   pm_addr,
  input logic [WORD_W-1:0] pm_data,
  input logic              done,
  input logic              accept,
  input logic              capture,
  input logic [HI_W-1:0]   hi_q
);
  a_r2_cur_page: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_last_page |=> pm_addr[PC_W-1 -: PG_W] == $past(pc_page));

  a_r3_last_page: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_last_page |=> pm_addr[PC_W-1 -: PG_W] == {PG_W{1'b1}});

  a_r5_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> hi_q == $past(pm_data[WORD_W-1 -: HI_W]));

  a_r5_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == HI_ADDR |-> reg_rdata[7:HI_W] == '0);

  a_r7_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(hi_q));

  a_r8_strobe_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pm_rd && !done);

  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |=> done && !pm_rd);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> !accept);
endmodule

bind tbl_read_unit tbl_read_chk #(
  .WORD_W(WORD_W), .PC_W(PC_W), .PG_W(PG_W), .HI_W(HI_W),
  .RA_W(RA_W), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_last_page(req_last_page), .pc_page(pc_page),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pm_rd(pm_rd), .pm_addr(pm_addr),
  .pm_data(pm_data), .done(done), .accept(accept), .capture(capture), .hi_q(hi_q)
);

// File: tb/tbl_read_unit_bench.sv
module tbl_read_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       req = 1'b0;
  logic       req_last_page = 1'b0;
  logic [1:0] pc_page = 2'd0;
  logic [9:0] pm_addr;
  logic       pm_rd;
  logic [13:0] pm_data;
  logic       done;
  logic [7:0] lo_byte;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] mem_word(input logic [9:0] a);
    return (14'(a) * 14'd173) ^ {a[3:0], a};
  endfunction

  assign pm_data = mem_word(pm_addr);

  tbl_read_unit u_tbl_read_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req),
    .req_last_page(req_last_page), .pc_page(pc_page), .pm_addr(pm_addr),
    .pm_rd(pm_rd), .pm_data(pm_data), .done(done), .lo_byte(lo_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Vector: {pointer[7:0], pc_page[1:0], last_page}
  localparam logic [10:0] VEC [8] = '{
    {8'h00, 2'd0, 1'b0}, {8'h5A, 2'd1, 1'b0}, {8'hFF, 2'd2, 1'b0},
    {8'h00, 2'd1, 1'b1}, {8'hFF, 2'd0, 1'b1}, {8'h81, 2'd3, 1'b0},
    {8'h3C, 2'd2, 1'b1}, {8'hC3, 2'd3, 1'b1}
  };

  initial begin : main
    logic [7:0] rv;
    logic [9:0] ea;
    logic [13:0] ew;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pm_rd", 32'(pm_rd), 0);
    chk("R1 done", 32'(done), 0);
    rd_reg(8'h07, rv); chk("R1 pointer", 32'(rv), 0);
    rd_reg(8'h08, rv); chk("R1 high reg", 32'(rv), 0);

    for (int i = 0; i < 8; i++) begin
      wr_reg(8'h07, VEC[i][10:3]);
      rd_reg(8'h07, rv); chk("R6 pointer readback", 32'(rv), 32'(VEC[i][10:3]));
      ea = VEC[i][0] ? {2'b11, VEC[i][10:3]} : {VEC[i][2:1], VEC[i][10:3]};
      ew = mem_word(ea);
      req = 1'b1; req_last_page = VEC[i][0]; pc_page = VEC[i][2:1];
      @(negedge clk);
      req = 1'b0; pc_page = ~VEC[i][2:1];
      #1;
      chk("R8 strobe", 32'(pm_rd), 1);
      chk(VEC[i][0] ? "R3 last-page addr" : "R2 cur-page addr", 32'(pm_addr), 32'(ea));
      chk("R8 no early done", 32'(done), 0);
      @(negedge clk);
      #1;
      chk("R8 done", 32'(done), 1);
      chk("R4 low byte", 32'(lo_byte), 32'(ew[7:0]));
      rd_reg(8'h08, rv); chk("R5 high reg", 32'(rv), 32'({2'b00, ew[13:8]}));
      @(negedge clk);
      #1 chk("R8 done one cycle", 32'(done), 0);
    end

    // R6 unmapped read
    rd_reg(8'h05, rv); chk("R6 unmapped read", 32'(rv), 0);
    rd_reg(8'h09, rv); chk("R6 unmapped read", 32'(rv), 0);

    // R7 write to high reg ignored (last word was 0x3C3)
    ew = mem_word(10'h3C3);
    wr_reg(8'h08, 8'hFF);
    rd_reg(8'h08, rv); chk("R7 high reg write ignored", 32'(rv), 32'({2'b00, ew[13:8]}));
    chk("R7 no done", 32'(done), 0);

    // R10 pointer write and request together
    wr_reg(8'h07, 8'h10);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'h07; reg_wdata = 8'h40;
    req = 1'b1; req_last_page = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; req = 1'b0;
    #1 chk("R10 old pointer used", 32'(pm_addr), 32'h310);
    rd_reg(8'h07, rv); chk("R10 pointer written", 32'(rv), 32'h40);
    @(negedge clk);
    #1 chk("R4 low byte 310", 32'(lo_byte), 32'(mem_word(10'h310) & 14'hFF));
    @(negedge clk);

    // R9 request during strobe cycle ignored
    req = 1'b1; req_last_page = 1'b1;
    @(negedge clk);
    req_last_page = 1'b0; pc_page = 2'd1;   // req still high in strobe cycle
    #1 chk("R9 strobe", 32'(pm_rd), 1);
    @(negedge clk);
    req = 1'b0;
    #1 chk("R9 done", 32'(done), 1);
    chk("R9 low byte 340", 32'(lo_byte), 32'(mem_word(10'h340) & 14'hFF));
    @(negedge clk);
    #1 chk("R9 busy request dropped", 32'(pm_rd), 0);

    // R9 request in done cycle accepted
    req = 1'b1; req_last_page = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; req_last_page = 1'b0; pc_page = 2'd2;
    #1 chk("R9 done before back-to-back", 32'(done), 1);
    @(negedge clk);
    req = 1'b0;
    #1 chk("R9 back-to-back strobe", 32'(pm_rd), 1);
    chk("R9 back-to-back addr", 32'(pm_addr), 32'h240);
    @(negedge clk);
    #1 chk("R9 back-to-back low byte", 32'(lo_byte), 32'(mem_word(10'h240) & 14'hFF));

    // R1 reset clears registers again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_reg(8'h07, rv); chk("R1 pointer after reset", 32'(rv), 0);
    rd_reg(8'h08, rv); chk("R1 high after reset", 32'(rv), 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule